// File: doc/BRIEF.md
# Register Rename Stage with Move and Zero Elimination

This block renames one instruction per cycle. It keeps a table that maps each architectural register to a physical register tag. For each accepted instruction it reports the physical tags of both sources and the tag the destination now maps to.

Two kinds of instruction finish inside the table and are flagged so that later stages can skip dispatching them:

- **Register move.** The destination entry takes a copy of the source's current tag. A consumer of the destination then depends directly on the original producer.
- **Zero idiom.** This is an xor or subtract whose two sources name the same register. The destination entry takes the reserved tag 0, which always reads as zero.

Every other instruction that writes a register takes a fresh tag from a free-list input. If no fresh tag is available, rename holds off the upstream stage.

Top module: `regRenameMoveElim`

## Requirements
- R1: After reset, architectural register i maps to physical tag i+1, and `outValid` is low until an instruction is accepted.
- R2: An instruction of class 2'b00 (ALU with destination) asserts `freeTake` in the cycle it is accepted. It reports `freeTag` as its destination tag with `eliminated` low, and later reads of that destination return `freeTag`.
- R3: A class 2'b01 instruction (move from `srcA` to `dst`) reports the current tag of `srcA` as its destination tag with `eliminated` high. It does not assert `freeTake`, and later reads of `dst` return that copied tag.
- R4: A class 2'b10 instruction (xor/subtract) whose `srcA` equals `srcB` reports destination tag 0 with `eliminated` high and does not assert `freeTake`. Later reads of its destination return tag 0.
- R5: A class 2'b10 instruction with different sources is handled like class 2'b00. It takes a fresh tag and `eliminated` is low.
- R6: When an instruction needs a fresh tag and `freeValid` is low, `inReady` is low, `freeTake` is low, no output is produced and the table is unchanged. Moves, zero idioms and class 2'b11 instructions are accepted whatever the value of `freeValid`.
- R7: Source tags are read before the same instruction updates the table. An instruction that names one register as both source and destination therefore reports the old mapping for that source.
- R8: A class 2'b11 instruction (no destination) reports its source tags with `outDstValid` low, `dstTag` 0 and `eliminated` low. It leaves the table unchanged and takes no tag.
- R9: Outputs are registered. `outValid` is high in exactly the cycle after an accepting clock edge and low after an edge with no acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Instruction present |
| inReady | output | 1 | Rename can accept the instruction |
| opClass | input | 2 | 00 ALU, 01 move, 10 xor/sub, 11 no destination |
| srcA | input | 4 | First source architectural register (move source) |
| srcB | input | 4 | Second source architectural register |
| dst | input | 4 | Destination architectural register |
| freeValid | input | 1 | A fresh physical tag is offered |
| freeTag | input | 6 | The offered tag (never 0) |
| freeTake | output | 1 | The offered tag is consumed this cycle |
| outValid | output | 1 | Renamed result valid |
| srcTagA | output | 6 | Physical tag of srcA |
| srcTagB | output | 6 | Physical tag of srcB |
| dstTag | output | 6 | New physical tag of dst |
| outDstValid | output | 1 | Instruction had a destination |
| eliminated | output | 1 | Move or zero idiom, skip dispatch |

## Verification
The bench keeps its own map of the table and runs every class of instruction through it:

- **Plain writes.** These show that a fresh tag is taken.
- **Moves followed by reads of the target.** These separate a copied tag from an allocated one.
- **Xor/sub pairs with equal sources and with unequal sources.** These separate the zero idiom from an ordinary write.
- **Instructions whose source and destination are the same register.** These expose read-after-update ordering.
- **Runs with no free tag offered.** These show that only allocating instructions stall.

A full sweep of no-destination reads checks the reset mapping and shows that reads leave the table untouched.

// File: rtl/renamePkg.sv
package renamePkg;

  typedef enum logic [1:0] {
    OP_ALU   = 2'b00,
    OP_MOVE  = 2'b01,
    OP_XSUB  = 2'b10,
    OP_NODST = 2'b11
  } opClassE;

  // strobes from control to the map datapath
  typedef struct packed {
    logic accept;
    logic wrNew;
    logic wrCopy;
    logic wrZero;
    logic elim;
    logic hasDst;
  } renStrobeT;

endpackage

// File: rtl/renameCtrl.sv
module renameCtrl
  import renamePkg::*;
#(
  parameter int ARCH_REGS = 16,
  localparam int ARCH_W = $clog2(ARCH_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [1:0]        opClass,
  input  logic [ARCH_W-1:0] srcA,
  input  logic [ARCH_W-1:0] srcB,
  input  logic              freeValid,
  output logic              inReady,
  output logic              freeTake,
  output renStrobeT         strobe
);

  logic isMove;
  logic isZeroIdiom;
  logic needsFree;
  logic accept;

  always_comb begin
    isMove      = (opClass == OP_MOVE);
    isZeroIdiom = (opClass == OP_XSUB) && (srcA == srcB);
    needsFree   = (opClass == OP_ALU) || ((opClass == OP_XSUB) && !isZeroIdiom);
    inReady     = !needsFree || freeValid;
    accept      = inValid && inReady;
    freeTake    = accept && needsFree;

    strobe.accept = accept;
    strobe.wrNew  = accept && needsFree;
    strobe.wrCopy = accept && isMove;
    strobe.wrZero = accept && isZeroIdiom;
    strobe.elim   = isMove || isZeroIdiom;
    strobe.hasDst = (opClass != OP_NODST);
  end

  // R2: a tag is only consumed when one is offered
  a_r2_take_needs_offer: assert property (@(posedge clk) disable iff (!rstN)
    freeTake |-> freeValid);

  // R6: a stalled instruction never consumes a tag
  a_r6_stall_no_take: assert property (@(posedge clk) disable iff (!rstN)
    !inReady |-> !freeTake);

  // R3/R4: eliminated work never allocates
  a_r4_elim_no_take: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.accept && strobe.elim) |-> !freeTake);

endmodule

// File: rtl/renameMapData.sv
module renameMapData
  import renamePkg::*;
#(
  parameter int ARCH_REGS = 16,
  parameter int PHYS_REGS = 64,
  localparam int ARCH_W = $clog2(ARCH_REGS),
  localparam int TAG_W  = $clog2(PHYS_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  renStrobeT         strobe,
  input  logic [ARCH_W-1:0] srcA,
  input  logic [ARCH_W-1:0] srcB,
  input  logic [ARCH_W-1:0] dst,
  input  logic [TAG_W-1:0]  freeTag,
  output logic              outValid,
  output logic [TAG_W-1:0]  srcTagA,
  output logic [TAG_W-1:0]  srcTagB,
  output logic [TAG_W-1:0]  dstTag,
  output logic              outDstValid,
  output logic              eliminated
);

  localparam logic [TAG_W-1:0] ZERO_TAG = '0;

  logic [TAG_W-1:0] mapTbl [ARCH_REGS];
  logic [TAG_W-1:0] readA;
  logic [TAG_W-1:0] readB;
  logic [TAG_W-1:0] nextTag;
  logic             tblWr;

  always_comb begin
    readA = mapTbl[srcA];
    readB = mapTbl[srcB];
    tblWr = strobe.wrNew || strobe.wrCopy || strobe.wrZero;
    if (strobe.wrZero)      nextTag = ZERO_TAG;
    else if (strobe.wrCopy) nextTag = readA;
    else                    nextTag = freeTag;
  end

  // one register per architectural entry; reset maps entry g to tag g+1
  for (genvar g = 0; g < ARCH_REGS; g++) begin : gEntry
    always_ff @(posedge clk) begin
      if (!rstN)
        mapTbl[g] <= TAG_W'(g + 1);
      else if (tblWr && (dst == ARCH_W'(g)))
        mapTbl[g] <= nextTag;
    end
  end

  // output stage: sources captured from the pre-update table
  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid    <= 1'b0;
      srcTagA     <= '0;
      srcTagB     <= '0;
      dstTag      <= '0;
      outDstValid <= 1'b0;
      eliminated  <= 1'b0;
    end else begin
      outValid <= strobe.accept;
      if (strobe.accept) begin
        srcTagA     <= readA;
        srcTagB     <= readB;
        dstTag      <= strobe.hasDst ? nextTag : ZERO_TAG;
        outDstValid <= strobe.hasDst;
        eliminated  <= strobe.elim;
      end
    end
  end

  // R9: each acceptance yields a result on the next cycle
  a_r9_accept_to_valid: assert property (@(posedge clk) disable iff (!rstN)
    strobe.accept |=> outValid);

  // R9: no acceptance, no result
  a_r9_idle_no_valid: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.accept |=> !outValid);

  // R8: no-destination instructions never claim elimination
  a_r8_nodst_not_elim: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outDstValid) |-> !eliminated);

  // R2: a non-eliminated write never lands on the zero tag (free list never offers 0)
  a_r2_alloc_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outDstValid && !eliminated) |-> (dstTag != ZERO_TAG));

endmodule

// File: rtl/regRenameMoveElim.sv
module regRenameMoveElim
  import renamePkg::*;
#(
  parameter int ARCH_REGS = 16,
  parameter int PHYS_REGS = 64
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         inValid,
  output logic                         inReady,
  input  logic [1:0]                   opClass,
  input  logic [$clog2(ARCH_REGS)-1:0] srcA,
  input  logic [$clog2(ARCH_REGS)-1:0] srcB,
  input  logic [$clog2(ARCH_REGS)-1:0] dst,
  input  logic                         freeValid,
  input  logic [$clog2(PHYS_REGS)-1:0] freeTag,
  output logic                         freeTake,
  output logic                         outValid,
  output logic [$clog2(PHYS_REGS)-1:0] srcTagA,
  output logic [$clog2(PHYS_REGS)-1:0] srcTagB,
  output logic [$clog2(PHYS_REGS)-1:0] dstTag,
  output logic                         outDstValid,
  output logic                         eliminated
);

  renStrobeT strobe;

  renameCtrl #(.ARCH_REGS(ARCH_REGS)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .opClass   (opClass),
    .srcA      (srcA),
    .srcB      (srcB),
    .freeValid (freeValid),
    .inReady   (inReady),
    .freeTake  (freeTake),
    .strobe    (strobe)
  );

  renameMapData #(.ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS)) data_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .srcA        (srcA),
    .srcB        (srcB),
    .dst         (dst),
    .freeTag     (freeTag),
    .outValid    (outValid),
    .srcTagA     (srcTagA),
    .srcTagB     (srcTagB),
    .dstTag      (dstTag),
    .outDstValid (outDstValid),
    .eliminated  (eliminated)
  );

endmodule

// File: tb/regRenameMoveElim_tb_top.sv
`timescale 1ns/1ps
module regRenameMoveElim_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       inValid = 1'b0;
  logic [1:0] opClass = 2'b11;
  logic [3:0] srcA = '0, srcB = '0, dst = '0;
  logic       freeValid = 1'b0;
  logic [5:0] freeTag = '0;
  logic       inReady, freeTake, outValid, outDstValid, eliminated;
  logic [5:0] srcTagA, srcTagB, dstTag;

  int vectors = 0;
  int errors  = 0;
  int mdl [16];
  bit finished = 0;

  always #2 clk = ~clk;

  regRenameMoveElim dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .opClass(opClass), .srcA(srcA), .srcB(srcB), .dst(dst),
    .freeValid(freeValid), .freeTag(freeTag), .freeTake(freeTake),
    .outValid(outValid), .srcTagA(srcTagA), .srcTagB(srcTagB),
    .dstTag(dstTag), .outDstValid(outDstValid), .eliminated(eliminated)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // applies one instruction at a negedge and checks it against the bench map
  task automatic doOp(input logic [1:0] cls, input int a, input int b, input int d,
                      input logic fv, input int ft, input string req);
    bit zeroId    = (cls == 2'b10) && (a == b);
    bit needsFree = (cls == 2'b00) || ((cls == 2'b10) && !zeroId);
    bit accepts   = !needsFree || fv;
    int expA = mdl[a];
    int expB = mdl[b];
    int expD;
    bit expElim = (cls == 2'b01) || zeroId;
    if (cls == 2'b11)      expD = 0;
    else if (cls == 2'b01) expD = mdl[a];
    else if (zeroId)       expD = 0;
    else                   expD = ft;
    inValid = 1'b1; opClass = cls; srcA = 4'(a); srcB = 4'(b); dst = 4'(d);
    freeValid = fv; freeTag = 6'(ft);
    #0.5;
    check(inReady == accepts, req, "inReady", int'(inReady), int'(accepts));
    check(freeTake == (accepts && needsFree), req, "freeTake", int'(freeTake),
          int'(accepts && needsFree));
    @(posedge clk); #1;
    inValid = 1'b0; freeValid = 1'b0;
    check(outValid == accepts, req, "outValid", int'(outValid), int'(accepts));
    if (accepts) begin
      check(int'(srcTagA) == expA, req, "srcTagA", int'(srcTagA), expA);
      check(int'(srcTagB) == expB, req, "srcTagB", int'(srcTagB), expB);
      check(int'(dstTag) == expD, req, "dstTag", int'(dstTag), expD);
      check(outDstValid == (cls != 2'b11), req, "outDstValid", int'(outDstValid),
            int'(cls != 2'b11));
      check(eliminated == expElim, req, "eliminated", int'(eliminated), int'(expElim));
      if (cls != 2'b11) mdl[d] = expD;
    end
    @(negedge clk);
  endtask

  // R8 read-back of one register through a no-destination instruction
  task automatic readReg(input int r, input string req);
    doOp(2'b11, r, r, 0, 1'b0, 0, req);
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < 16; i++) mdl[i] = i + 1;
    check(outValid == 1'b0, "R1", "outValid after reset", int'(outValid), 0);
    for (int i = 0; i < 16; i++) readReg(i, "R1");
    for (int i = 0; i < 16; i++) readReg(i, "R8");
  endtask

  task automatic testAlloc();
    doOp(2'b00, 1, 2, 3, 1'b1, 40, "R2");
    readReg(3, "R2");
  endtask

  task automatic testMove();
    doOp(2'b01, 3, 0, 5, 1'b1, 50, "R3");
    doOp(2'b00, 5, 6, 8, 1'b1, 43, "R3");
    readReg(5, "R3");
  endtask

  task automatic testZero();
    doOp(2'b10, 7, 7, 7, 1'b1, 51, "R4");
    readReg(7, "R4");
    doOp(2'b10, 9, 9, 10, 1'b1, 52, "R4");
    doOp(2'b00, 10, 7, 11, 1'b1, 44, "R4");
  endtask

  task automatic testXsubDiff();
    doOp(2'b10, 1, 2, 12, 1'b1, 45, "R5");
    readReg(12, "R5");
  endtask

  task automatic testStall();
    doOp(2'b00, 1, 2, 13, 1'b0, 46, "R6");
    doOp(2'b10, 1, 2, 13, 1'b0, 46, "R6");
    readReg(13, "R6");
    doOp(2'b01, 12, 0, 13, 1'b0, 0, "R6");
    doOp(2'b10, 14, 14, 14, 1'b0, 0, "R6");
    readReg(13, "R6");
  endtask

  task automatic testSameReg();
    doOp(2'b00, 4, 4, 4, 1'b1, 47, "R7");
    readReg(4, "R7");
    doOp(2'b10, 15, 2, 15, 1'b1, 48, "R7");
  endtask

  task automatic testIdle();
    @(posedge clk); #1;
    check(outValid == 1'b0, "R9", "outValid idle", int'(outValid), 0);
    @(negedge clk);
    doOp(2'b00, 0, 1, 2, 1'b1, 49, "R9");
    @(posedge clk); #1;
    check(outValid == 1'b0, "R9", "outValid after single op", int'(outValid), 0);
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    testReset();
    testAlloc();
    testMove();
    testZero();
    testXsubDiff();
    testStall();
    testSameReg();
    testIdle();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule